// File: doc/BRIEF.md
# Dual-Channel Synchronized Serial Launch

This block starts bit-serial transmission on two redundant transmit lines from one host command. The two start times are either identical to the clock cycle or offset by an exact, programmed number of cycles. Each channel has its own byte queue, which the host fills ahead of time. Filling a queue never starts a transmission. Only a command does.

A command carries a two-bit channel mask. The block registers the mask for one cycle and then clears it. It then places a one-shot start token into a single-entry holder for each selected channel. Each transmitter takes its token out of the holder when it accepts it, so the host never has to clear a flag.

An optional skew value holds back one chosen channel's token by a cycle count. This gives a deliberate lag between the two lines. A command aimed at a channel that is still working is refused for that channel, and the refusal is latched in a sticky error bit.

Top module: `dual_tx_launch`

## Requirements
- R1: After synchronous reset both lines are high, both active flags and both done flags are low, the error bit is low and both queues report not full.
- R2: Writing bytes into a queue, or issuing a command with a mask of zero, never starts a transmission and never sets the error bit.
- R3: Command mask bit 0 selects channel A and bit 1 selects channel B. A channel that is not selected keeps its line high and its queue untouched.
- R4: When both channels are selected and the skew count is zero, both first bits appear on the same clock cycle.
- R5: Bytes go out LSB first. Each bit is held for `baud_div` cycles, and a value of 0 counts as 1. Queued bytes follow each other with no gap. The line is high whenever the channel is not active. With no skew, the first bit appears 3 cycles after the edge that samples `cmd_wr`.
- R6: The cycle after the last bit ends, the active flag falls, the line returns high and done is high for exactly one cycle.
- R7: A channel whose queue is empty when its token arrives consumes the token, pulses done 2 cycles after the command edge (plus any skew) and leaves its line high.
- R8: `skew_cfg[16]` names the lagging channel: 1 means B lags and 0 means A lags. `skew_cfg[15:0]` is the lag in cycles, and it applies whenever the lagging channel is selected.
- R9: A command that selects a channel which is still waiting, delaying or transmitting sets `cmd_err`. The command is ignored for that channel and still served for an idle selected channel. `cmd_err` stays set until reset.
- R10: Each token starts one transmission only. Data written after a transmission ends is not sent until a new command arrives.
- R11: Each queue holds `FIFO_DEPTH` bytes and raises its full flag when it has that many. Writes made while it is full are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_sel | input | 2 | Channel mask (bit 0 = A, bit 1 = B) |
| skew_cfg | input | SKEW_W+1 | Lag count in the low bits, lagging channel in the top bit |
| baud_div | input | DIV_W | Cycles per bit (0 counts as 1) |
| a_load | input | 1 | Write strobe for the channel A queue |
| a_load_data | input | DATA_W | Byte for the channel A queue |
| a_full | output | 1 | Channel A queue full |
| b_load | input | 1 | Write strobe for the channel B queue |
| b_load_data | input | DATA_W | Byte for the channel B queue |
| b_full | output | 1 | Channel B queue full |
| tx_a | output | 1 | Channel A serial line |
| tx_b | output | 1 | Channel B serial line |
| act_a | output | 1 | Channel A transmitting |
| act_b | output | 1 | Channel B transmitting |
| done_a | output | 1 | Channel A finished (one-cycle pulse) |
| done_b | output | 1 | Channel B finished (one-cycle pulse) |
| cmd_err | output | 1 | Sticky flag for a refused command |

## Verification
A token that is left behind or counted twice shows as a second done pulse or a second frame, at most three cycles after the channel goes idle. A wrong skew or bit counter moves the first bit or a bit boundary by whole cycles, and a cycle-exact comparison of the lines sees this on the first affected bit. A wrong busy decision shows in `cmd_err` one cycle after the command, or as a transmission that restarts in the middle of a frame.

// File: rtl/dtl_pkg.sv
package dtl_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_FETCH = 2'd1,
    TX_SHIFT = 2'd2
  } tx_state_e;
endpackage

// File: rtl/dtl_fifo.sv
// Byte queue with registered read port, written for block RAM inference.
module dtl_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr;
  logic [AW:0]  rptr;

  assign empty = (wptr == rptr);
  assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);

  always_ff @(posedge clk) begin
    if (wr_en && !full) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en && !empty) rd_data <= mem[rptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en && !full) wptr <= wptr + 1'b1;
      if (rd_en && !empty) rptr <= rptr + 1'b1;
    end
  end
endmodule

// File: rtl/dtl_dispatch.sv
// Command register, per-channel lag counters and single-entry start tokens.
module dtl_dispatch
  import dtl_pkg::*;
#(
  parameter int SKEW_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [NCH-1:0]    cmd_sel,
  input  logic [SKEW_W-1:0] skew_cnt,
  input  logic              skew_late,
  input  logic [NCH-1:0]    ch_busy,
  input  logic [NCH-1:0]    tok_pop,
  output logic [NCH-1:0]    tok_vld,
  output logic              cmd_err
);
  logic [NCH-1:0] cmd_q;
  logic [NCH-1:0] reject;

  // Command register: holds a nonzero mask for one cycle, then clears itself.
  always_ff @(posedge clk) begin
    if (rst) cmd_q <= '0;
    else     cmd_q <= (cmd_wr && (cmd_sel != '0)) ? cmd_sel : '0;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic              late_this;
    logic [SKEW_W-1:0] my_delay;
    logic              dly_pend;
    logic [SKEW_W-1:0] dly_q;
    logic              tok_q;
    logic              occupied;
    logic              accept;

    assign late_this = (skew_late == (g != 0));
    assign my_delay  = late_this ? skew_cnt : '0;
    assign occupied  = tok_q | dly_pend | ch_busy[g];
    assign accept    = cmd_q[g] & ~occupied;
    assign reject[g] = cmd_q[g] & occupied;
    assign tok_vld[g] = tok_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        tok_q    <= 1'b0;
        dly_pend <= 1'b0;
        dly_q    <= '0;
      end else begin
        if (tok_pop[g]) tok_q <= 1'b0;
        if (accept) begin
          if (my_delay == '0) begin
            tok_q <= 1'b1;
          end else begin
            dly_pend <= 1'b1;
            dly_q    <= my_delay;
          end
        end else if (dly_pend) begin
          if (dly_q == SKEW_W'(1)) begin
            dly_pend <= 1'b0;
            tok_q    <= 1'b1;
          end else begin
            dly_q <= dly_q - 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               cmd_err <= 1'b0;
    else if (reject != '0) cmd_err <= 1'b1;
  end
endmodule

// File: rtl/dtl_serializer.sv
// Bit-serial transmitter: takes a token, drains its queue LSB first.
module dtl_serializer
  import dtl_pkg::*;
#(
  parameter int W     = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             tok_vld,
  output logic             tok_pop,
  input  logic             fifo_empty,
  input  logic [W-1:0]     fifo_rdata,
  output logic             fifo_rd,
  output logic             busy,
  output logic             tx,
  output logic             tx_act,
  output logic             done
);
  localparam int BIT_W = $clog2(W);

  tx_state_e        state;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;
  logic [BIT_W-1:0] bitcnt;
  logic [W-1:0]     shreg;
  logic             nxt;
  logic             pref_rd;

  assign div_eff = (baud_div == '0) ? DIV_W'(1) : baud_div;
  assign tok_pop = (state == TX_IDLE) && tok_vld;
  // Fetch the following byte when the last bit of the current one starts.
  assign pref_rd = (state == TX_SHIFT) && (cnt == '0) &&
                   (bitcnt == BIT_W'(W-2)) && !fifo_empty;
  assign fifo_rd = (tok_pop && !fifo_empty) || pref_rd;
  assign busy    = (state != TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TX_IDLE;
      tx     <= 1'b1;
      tx_act <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      bitcnt <= '0;
      shreg  <= '0;
      nxt    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        TX_IDLE: begin
          if (tok_vld) begin
            if (fifo_empty) done  <= 1'b1;
            else            state <= TX_FETCH;
          end
        end
        TX_FETCH: begin
          shreg  <= fifo_rdata;
          tx     <= fifo_rdata[0];
          tx_act <= 1'b1;
          bitcnt <= '0;
          cnt    <= div_eff - DIV_W'(1);
          nxt    <= 1'b0;
          state  <= TX_SHIFT;
        end
        TX_SHIFT: begin
          if (cnt != '0) begin
            cnt <= cnt - DIV_W'(1);
          end else if (bitcnt != BIT_W'(W-1)) begin
            shreg  <= shreg >> 1;
            tx     <= shreg[1];
            bitcnt <= bitcnt + 1'b1;
            cnt    <= div_eff - DIV_W'(1);
            if (pref_rd) nxt <= 1'b1;
          end else if (nxt) begin
            shreg  <= fifo_rdata;
            tx     <= fifo_rdata[0];
            bitcnt <= '0;
            cnt    <= div_eff - DIV_W'(1);
            nxt    <= 1'b0;
          end else begin
            state  <= TX_IDLE;
            tx     <= 1'b1;
            tx_act <= 1'b0;
            done   <= 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dual_tx_launch.sv
module dual_tx_launch
  import dtl_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int SKEW_W     = 16,
  parameter int DIV_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd_sel,
  input  logic [SKEW_W:0]   skew_cfg,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              a_load,
  input  logic [DATA_W-1:0] a_load_data,
  output logic              a_full,
  input  logic              b_load,
  input  logic [DATA_W-1:0] b_load_data,
  output logic              b_full,
  output logic              tx_a,
  output logic              tx_b,
  output logic              act_a,
  output logic              act_b,
  output logic              done_a,
  output logic              done_b,
  output logic              cmd_err
);
  logic [NCH-1:0]    tok_vld;
  logic [NCH-1:0]    tok_pop;
  logic [NCH-1:0]    ch_busy;
  logic [NCH-1:0]    ld_wr;
  logic [DATA_W-1:0] ld_data [NCH];
  logic [NCH-1:0]    q_full;
  logic [NCH-1:0]    q_empty;
  logic [NCH-1:0]    q_rd;
  logic [DATA_W-1:0] q_rdata [NCH];
  logic [NCH-1:0]    tx_w;
  logic [NCH-1:0]    act_w;
  logic [NCH-1:0]    done_w;

  assign ld_wr      = {b_load, a_load};
  assign ld_data[0] = a_load_data;
  assign ld_data[1] = b_load_data;

  dtl_dispatch #(.SKEW_W(SKEW_W)) u_dispatch (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_sel   (cmd_sel),
    .skew_cnt  (skew_cfg[SKEW_W-1:0]),
    .skew_late (skew_cfg[SKEW_W]),
    .ch_busy   (ch_busy),
    .tok_pop   (tok_pop),
    .tok_vld   (tok_vld),
    .cmd_err   (cmd_err)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    dtl_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (ld_wr[g]),
      .wr_data (ld_data[g]),
      .rd_en   (q_rd[g]),
      .rd_data (q_rdata[g]),
      .empty   (q_empty[g]),
      .full    (q_full[g])
    );

    dtl_serializer #(.W(DATA_W), .DIV_W(DIV_W)) u_ser (
      .clk        (clk),
      .rst        (rst),
      .baud_div   (baud_div),
      .tok_vld    (tok_vld[g]),
      .tok_pop    (tok_pop[g]),
      .fifo_empty (q_empty[g]),
      .fifo_rdata (q_rdata[g]),
      .fifo_rd    (q_rd[g]),
      .busy       (ch_busy[g]),
      .tx         (tx_w[g]),
      .tx_act     (act_w[g]),
      .done       (done_w[g])
    );
  end

  assign a_full = q_full[0];
  assign b_full = q_full[1];
  assign tx_a   = tx_w[0];
  assign tx_b   = tx_w[1];
  assign act_a  = act_w[0];
  assign act_b  = act_w[1];
  assign done_a = done_w[0];
  assign done_b = done_w[1];
endmodule

// File: rtl/dtl_check.sv
module dtl_check (
  input logic       clk,
  input logic       rst,
  input logic       tx_a,
  input logic       tx_b,
  input logic       act_a,
  input logic       act_b,
  input logic       done_a,
  input logic       done_b,
  input logic       cmd_err,
  input logic [1:0] tok_vld,
  input logic [1:0] tok_pop
);
  assert_idle_high_a_R5: assert property (@(posedge clk) disable iff (rst) !act_a |-> tx_a);
  assert_idle_high_b_R5: assert property (@(posedge clk) disable iff (rst) !act_b |-> tx_b);

  assert_done_single_a_R6: assert property (@(posedge clk) disable iff (rst) done_a |=> !done_a);
  assert_done_single_b_R6: assert property (@(posedge clk) disable iff (rst) done_b |=> !done_b);

  assert_done_inactive_a_R6: assert property (@(posedge clk) disable iff (rst) done_a |-> !act_a);
  assert_done_inactive_b_R6: assert property (@(posedge clk) disable iff (rst) done_b |-> !act_b);

  assert_start_token_a_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(act_a) |-> $past(tok_pop[0], 2));
  assert_start_token_b_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(act_b) |-> $past(tok_pop[1], 2));

  assert_token_kept_a_R10: assert property (@(posedge clk) disable iff (rst)
    (tok_vld[0] && !tok_pop[0]) |=> tok_vld[0]);
  assert_token_kept_b_R10: assert property (@(posedge clk) disable iff (rst)
    (tok_vld[1] && !tok_pop[1]) |=> tok_vld[1]);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst) cmd_err |=> cmd_err);
endmodule

bind dual_tx_launch dtl_check u_dtl_check (
  .clk     (clk),
  .rst     (rst),
  .tx_a    (tx_a),
  .tx_b    (tx_b),
  .act_a   (act_a),
  .act_b   (act_b),
  .done_a  (done_a),
  .done_b  (done_b),
  .cmd_err (cmd_err),
  .tok_vld (tok_vld),
  .tok_pop (tok_pop)
);

// File: tb/test_dual_tx_launch.sv
module test_dual_tx_launch;
  localparam int DW    = 8;
  localparam int DEPTH = 4;
  localparam int SW    = 16;
  localparam int VW    = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_wr = 1'b0;
  logic [1:0]    cmd_sel = '0;
  logic [SW:0]   skew_cfg = '0;
  logic [VW-1:0] baud_div = VW'(1);
  logic          a_load = 1'b0;
  logic [DW-1:0] a_load_data = '0;
  logic          b_load = 1'b0;
  logic [DW-1:0] b_load_data = '0;
  logic a_full, b_full, tx_a, tx_b, act_a, act_b, done_a, done_b, cmd_err;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dual_tx_launch #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .SKEW_W(SW), .DIV_W(VW)) i_dual_tx_launch (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel), .skew_cfg(skew_cfg),
    .baud_div(baud_div), .a_load(a_load), .a_load_data(a_load_data), .a_full(a_full),
    .b_load(b_load), .b_load_data(b_load_data), .b_full(b_full), .tx_a(tx_a), .tx_b(tx_b),
    .act_a(act_a), .act_b(act_b), .done_a(done_a), .done_b(done_b), .cmd_err(cmd_err)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int ch, int base, int m);
    return 8'((base * 29 + m * 83 + ch * 151 + 7) & 255);
  endfunction

  // Expected line, active and done at index k after the command edge.
  function automatic logic exp_tx(int k, int start, int nb, int d, int ch, int base);
    logic [7:0] b;
    int rel;
    if (nb == 0 || k < start || k >= start + 8 * nb * d) return 1'b1;
    rel = k - start;
    b = pat(ch, base, rel / (8 * d));
    return b[(rel / d) % 8];
  endfunction

  function automatic logic exp_act(int k, int start, int nb, int d);
    return (nb > 0) && (k >= start) && (k < start + 8 * nb * d);
  endfunction

  function automatic logic exp_done(int k, int start, int nb, int d);
    return (nb == 0) ? (k == start - 1) : (k == start + 8 * nb * d);
  endfunction

  task automatic load(int ch, int n, int base);
    for (int m = 0; m < n; m++) begin
      @(negedge clk);
      if (ch == 0) begin a_load = 1'b1; a_load_data = pat(0, base, m); end
      else         begin b_load = 1'b1; b_load_data = pat(1, base, m); end
    end
    @(negedge clk);
    a_load = 1'b0;
    b_load = 1'b0;
  endtask

  task automatic launch(logic [1:0] sel);
    @(negedge clk);
    cmd_wr  = 1'b1;
    cmd_sel = sel;
  endtask

  task automatic watch(logic [1:0] sel, int nba, int nbb, int d, int late_b, int n, int base);
    int deff, dla, dlb, mx, stop;
    string ta, tb, da, db;
    deff = (d == 0) ? 1 : d;
    dla = (late_b == 0) ? n : 0;
    dlb = (late_b != 0) ? n : 0;
    mx = (nba > nbb) ? nba : nbb;
    stop = 3 + n + 8 * mx * deff + 3;
    ta = !sel[0] ? "R3" : (nba == 0) ? "R7" : (dla != 0) ? "R8" : (sel == 2'b11) ? "R4" : "R5";
    tb = !sel[1] ? "R3" : (nbb == 0) ? "R7" : (dlb != 0) ? "R8" : (sel == 2'b11) ? "R4" : "R5";
    da = (nba == 0) ? "R7" : "R6";
    db = (nbb == 0) ? "R7" : "R6";
    for (int k = 0; k <= stop; k++) begin
      @(negedge clk);
      if (k == 0) cmd_wr = 1'b0;
      if (sel[0]) begin
        chk(ta, "tx_a", 32'(tx_a), 32'(exp_tx(k, 3 + dla, nba, deff, 0, base)));
        chk(ta, "act_a", 32'(act_a), 32'(exp_act(k, 3 + dla, nba, deff)));
        chk(da, "done_a", 32'(done_a), 32'(exp_done(k, 3 + dla, nba, deff)));
      end else begin
        chk("R3", "tx_a idle", 32'(tx_a), 32'd1);
        chk("R3", "done_a idle", 32'(done_a), 32'd0);
      end
      if (sel[1]) begin
        chk(tb, "tx_b", 32'(tx_b), 32'(exp_tx(k, 3 + dlb, nbb, deff, 1, base)));
        chk(tb, "act_b", 32'(act_b), 32'(exp_act(k, 3 + dlb, nbb, deff)));
        chk(db, "done_b", 32'(done_b), 32'(exp_done(k, 3 + dlb, nbb, deff)));
      end else begin
        chk("R3", "tx_b idle", 32'(tx_b), 32'd1);
        chk("R3", "done_b idle", 32'(done_b), 32'd0);
      end
      chk("R9", "no error", 32'(cmd_err), 32'd0);
    end
  endtask

  task automatic run_case(logic [1:0] sel, int nba, int nbb, int d, int late_b, int n, int base);
    baud_div = VW'(d);
    skew_cfg = {1'(late_b), SW'(n)};
    if (sel[0]) load(0, nba, base);
    if (sel[1]) load(1, nbb, base);
    launch(sel);
    watch(sel, nba, nbb, d, late_b, n, base);
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int it;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "tx_a", 32'(tx_a), 32'd1);
    chk("R1", "tx_b", 32'(tx_b), 32'd1);
    chk("R1", "act", 32'({act_a, act_b}), 32'd0);
    chk("R1", "done", 32'({done_a, done_b}), 32'd0);
    chk("R1", "err", 32'(cmd_err), 32'd0);
    chk("R1", "full", 32'({a_full, b_full}), 32'd0);

    // R2: loading and a zero mask start nothing
    baud_div = VW'(2);
    skew_cfg = '0;
    load(0, 2, 11);
    load(1, 1, 11);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk("R2", "tx after load", 32'({tx_a, tx_b}), 32'd3);
      chk("R2", "act after load", 32'({act_a, act_b}), 32'd0);
    end
    launch(2'b00);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 0) cmd_wr = 1'b0;
      chk("R2", "zero mask act", 32'({act_a, act_b}), 32'd0);
      chk("R2", "zero mask done", 32'({done_a, done_b}), 32'd0);
      chk("R2", "zero mask err", 32'(cmd_err), 32'd0);
    end
    // R3: B alone while A holds data, then A alone
    launch(2'b10);
    watch(2'b10, 2, 1, 2, 0, 0, 11);
    launch(2'b01);
    watch(2'b01, 2, 1, 2, 0, 0, 11);

    // Sweep: divider, mask, lagging channel, lag, byte counts
    it = 0;
    for (int d = 1; d <= 3; d++)
      for (int s = 1; s <= 3; s++)
        for (int lb = 0; lb < 2; lb++)
          for (int ni = 0; ni < 3; ni++) begin
            run_case(2'(s), it % 3, (it + 1) % 3, d, lb, (ni == 0) ? 0 : (ni == 1) ? 1 : 5, it);
            it++;
          end
    // R5: divider 0 acts as 1
    run_case(2'b11, 2, 2, 0, 0, 0, 200);

    // R11: full flag and dropped writes
    load(0, DEPTH + 2, 90);
    chk("R11", "a_full", 32'(a_full), 32'd1);
    run_case(2'b01, DEPTH, 0, 1, 0, 0, 90);
    chk("R11", "a_full after drain", 32'(a_full), 32'd0);

    // R9: refused command while A transmits, B still served
    baud_div = VW'(3);
    skew_cfg = '0;
    load(0, 2, 50);
    launch(2'b01);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (k == 0) cmd_wr = 1'b0;
    end
    load(1, 1, 60);
    launch(2'b11);
    for (int k = 0; k <= 30; k++) begin
      @(negedge clk);
      if (k == 0) cmd_wr = 1'b0;
      chk("R9", "cmd_err", 32'(cmd_err), (k == 0) ? 32'd0 : 32'd1);
      chk("R9", "tx_b served", 32'(tx_b), 32'(exp_tx(k, 3, 1, 3, 1, 60)));
      chk("R9", "act_b served", 32'(act_b), 32'(exp_act(k, 3, 1, 3)));
    end
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (done_a) break;
    end
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      chk("R9", "A not restarted act", 32'(act_a), 32'd0);
      chk("R9", "A not restarted done", 32'(done_a), 32'd0);
    end
    // R10: data after a frame waits for a new command
    load(0, 1, 70);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk("R10", "tx_a held", 32'(tx_a), 32'd1);
      chk("R10", "act_a held", 32'(act_a), 32'd0);
    end
    chk("R9", "err sticky", 32'(cmd_err), 32'd1);
    launch(2'b01);
    for (int k = 0; k <= 30; k++) begin
      @(negedge clk);
      if (k == 0) cmd_wr = 1'b0;
      chk("R10", "tx_a new frame", 32'(tx_a), 32'(exp_tx(k, 3, 1, 3, 0, 70)));
    end
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "err after reset", 32'(cmd_err), 32'd0);
    chk("R1", "tx after reset", 32'({tx_a, tx_b}), 32'd3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule